// File: doc/BRIEF.md
# Scanline-Rate Interrupt Timer

This block raises a processor interrupt at a rate of roughly one count per video scanline, derived entirely from processor clock cycles. No connection to the picture generator is needed. Each processor cycle is worth a fixed number of video dots, three by default. A dot accumulator turns that flow into one tick per scanline period of 341 dots. Each tick advances an 8-bit up-counter. When the counter rolls over from its top value, it reloads from a stored start value and raises the interrupt request.

Software controls the timer with two write strobes. The arm strobe loads a new start value, restarts the dot accumulator, enables counting and drops any pending request. The stop strobe disables counting and drops the request. The start value arrives directly on an input port. The request is a level that stays high until one of the two strobes clears it.

Top module: `scanline_irq_timer`

## Requirements
- R1: After reset the timer is disabled, the request is low, and processor cycles do not advance anything until the first arm strobe.
- R2: While enabled, each cycle with `cyc_en` high adds 3 dots. When the total reaches 341 or more, 341 is taken off and the counter advances by one. With a start value of 0xFF, the request rises after exactly the 114th counted cycle following the arm strobe, and not earlier.
- R3: A tick that takes the counter from 0xFF to 0x00 instead reloads the counter from the stored start value and sets the request, which is visible after that clock edge. A start value of 0x00 therefore needs 256 ticks.
- R4: An arm strobe (without stop) stores `reload_val`, loads it into the counter, clears the dot total, enables the timer and clears the request on the next edge.
- R5: A stop strobe disables the timer and clears the request on the next edge.
- R6: While disabled, `cyc_en` pulses have no effect: the request stays low and the dot total and counter hold.
- R7: Cycles with `cyc_en` low add no dots, so gaps in `cyc_en` delay the request by exactly the number of skipped cycles.
- R8: Once set, the request stays high through later rollovers and reloads until an arm or stop strobe.
- R9: When arm and stop are strobed in the same cycle, stop takes effect: the timer ends disabled with the request low, and the start value is not stored.
- R10: The cycle carrying an arm strobe adds no dots even if `cyc_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | One processor cycle has elapsed |
| arm_wr | input | 1 | Strobe that loads the start value and enables the timer |
| stop_wr | input | 1 | Strobe that disables the timer and clears the request |
| reload_val | input | 8 | Start value for the counter |
| irq | output | 1 | Interrupt request, active high, held until cleared |

## Verification
A dense `cyc_en` with a start value of 0xFF pins the exact first-interrupt cycle, which exposes any error in the dot step, the period or the compare. A start value of 0xFE places the second tick after a non-zero leftover dot total, which shows whether the remainder is carried or discarded. Sparse random `cyc_en` patterns separate counting enabled cycles from counting clock edges. A start value of 0x00 exercises the longest interval. Random mixes of strobes, including arm and stop together and arm with `cyc_en` high, check the clearing and priority rules against a cycle-level bench model.

// File: rtl/sltmr_pkg.sv
package sltmr_pkg;

   // Decoded control action for one clock cycle
   typedef enum logic [1:0] {
      SLT_CMD_NONE = 2'd0,
      SLT_CMD_ARM  = 2'd1,
      SLT_CMD_STOP = 2'd2
   } slt_cmd_e;

endpackage

// File: rtl/sltmr_ctrl.sv
module sltmr_ctrl
   import sltmr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     arm_wr,
   input  logic     stop_wr,
   input  logic     wrap,
   output slt_cmd_e cmd,
   output logic     run,
   output logic     irq
);

   logic run_q;
   logic irq_q;

   // Stop has priority over arm
   always_comb begin
      if (stop_wr)     cmd = SLT_CMD_STOP;
      else if (arm_wr) cmd = SLT_CMD_ARM;
      else             cmd = SLT_CMD_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         unique case (cmd)
            SLT_CMD_STOP: begin
               run_q <= 1'b0;
               irq_q <= 1'b0;
            end
            SLT_CMD_ARM: begin
               run_q <= 1'b1;
               irq_q <= 1'b0;
            end
            default: begin
               if (wrap) irq_q <= 1'b1;
            end
         endcase
      end
   end

   assign run = run_q;
   assign irq = irq_q;

   assert_stop_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_wr |=> !run_q);
   assert_arm_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_wr && !stop_wr) |=> (run_q && !irq_q));
   assert_stop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stop_wr |=> !irq_q);
   assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !arm_wr && !stop_wr) |=> irq_q);
   assert_irq_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(wrap));

endmodule

// File: rtl/sltmr_prescale.sv
module sltmr_prescale #(
   parameter int STEP   = 3,
   parameter int PERIOD = 341
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic tick
);

   generate
      if (STEP < 1 || STEP >= PERIOD) begin : g_bad_step
         $error("sltmr_prescale: STEP must be in 1..PERIOD-1");
      end

      if (PERIOD % STEP == 0) begin : g_divider
         // The period is a whole number of cycles: a plain cycle counter is enough
         localparam int DIV = PERIOD / STEP;
         localparam int DW  = $clog2(DIV + 1);
         logic [DW-1:0] div_q;

         assign tick = adv && (div_q == DW'(DIV - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    div_q <= '0;
            else if (clr)  div_q <= '0;
            else if (tick) div_q <= '0;
            else if (adv)  div_q <= div_q + 1'b1;
         end

         assert_div_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
            div_q < DW'(DIV));
         assert_div_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!adv && !clr) |=> $stable(div_q));
      end else begin : g_accum
         // Fractional cycles per period: keep a dot remainder
         localparam int ACC_W = $clog2(PERIOD);
         localparam int SUM_W = ACC_W + 1;
         logic [ACC_W-1:0] acc_q;
         logic [SUM_W-1:0] sum;

         assign sum  = {1'b0, acc_q} + SUM_W'(STEP);
         assign tick = adv && (sum >= SUM_W'(PERIOD));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    acc_q <= '0;
            else if (clr)  acc_q <= '0;
            else if (tick) acc_q <= ACC_W'(sum - SUM_W'(PERIOD));
            else if (adv)  acc_q <= ACC_W'(sum);
         end

         assert_acc_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
            acc_q < ACC_W'(PERIOD));
         assert_acc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!adv && !clr) |=> $stable(acc_q));
         assert_acc_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (acc_q == '0));
      end
   endgenerate

endmodule

// File: rtl/sltmr_count.sv
module sltmr_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             tick,
   output logic             wrap
);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("sltmr_count: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] latch_q;

   assign wrap = tick && (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         latch_q <= '0;
      end else if (load) begin
         cnt_q   <= ld_val;
         latch_q <= ld_val;
      end else if (wrap) begin
         cnt_q   <= latch_q;
      end else if (tick) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(ld_val)) && (latch_q == $past(ld_val)));
   assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !load) |=> (cnt_q == latch_q));
   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wrap && !load) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> ($stable(cnt_q) && $stable(latch_q)));

endmodule

// File: rtl/scanline_irq_timer.sv
module scanline_irq_timer
   import sltmr_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int STEP   = 3,
   parameter int PERIOD = 341
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_en,
   input  logic             arm_wr,
   input  logic             stop_wr,
   input  logic [CNT_W-1:0] reload_val,
   output logic             irq
);

   slt_cmd_e cmd;
   logic     run;
   logic     tick;
   logic     wrap;
   logic     do_load;
   logic     do_adv;

   assign do_load = (cmd == SLT_CMD_ARM);
   assign do_adv  = run && cyc_en && (cmd == SLT_CMD_NONE);

   sltmr_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_wr  (arm_wr),
      .stop_wr (stop_wr),
      .wrap    (wrap),
      .cmd     (cmd),
      .run     (run),
      .irq     (irq)
   );

   sltmr_prescale #(
      .STEP   (STEP),
      .PERIOD (PERIOD)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (do_load),
      .adv   (do_adv),
      .tick  (tick)
   );

   sltmr_count #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (do_load),
      .ld_val (reload_val),
      .tick   (tick),
      .wrap   (wrap)
   );

   assert_idle_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick);
   assert_gap_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_en |-> !tick);

endmodule

// File: tb/tb_scanline_irq_timer.sv
module tb_scanline_irq_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_en = 1'b0;
   logic       arm_wr = 1'b0;
   logic       stop_wr = 1'b0;
   logic [7:0] reload_val = 8'h00;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;
   string cur_req = "R1";

   // Bench model state
   bit m_en = 0;
   int m_acc = 0;
   int m_cnt = 0;
   int m_latch = 0;
   bit m_irq = 0;

   always #2 clk = ~clk;

   scanline_irq_timer dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cyc_en     (cyc_en),
      .arm_wr     (arm_wr),
      .stop_wr    (stop_wr),
      .reload_val (reload_val),
      .irq        (irq)
   );

   task automatic check(input string req, input bit act, input bit exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: irq=%0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   // Model update for one clock, as the requirements state it
   task automatic model_step(input bit ce, input bit arm, input bit stp, input int val);
      if (stp) begin
         m_en = 0; m_irq = 0;
      end else if (arm) begin
         m_en = 1; m_latch = val; m_cnt = val; m_acc = 0; m_irq = 0;
      end else if (m_en && ce) begin
         m_acc += 3;
         if (m_acc >= 341) begin
            m_acc -= 341;
            m_cnt = (m_cnt + 1) & 255;
            if (m_cnt == 0) begin
               m_cnt = m_latch;
               m_irq = 1;
            end
         end
      end
   endtask

   task automatic step(input bit ce, input bit arm, input bit stp, input int val);
      @(negedge clk);
      cyc_en = ce; arm_wr = arm; stop_wr = stp; reload_val = 8'(val);
      model_step(ce, arm, stp, val);
      @(posedge clk);
      #1;
      check(cur_req, irq, m_irq);
   endtask

   task automatic run(input int n, input bit ce);
      for (int i = 0; i < n; i++) step(ce, 0, 0, 0);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(4 * 190000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
   end

   initial begin
      int r;
      r = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      #1 check("R1", irq, 1'b0);
      rst_n = 1'b1;

      // R1: disabled out of reset, cycles do nothing
      cur_req = "R1";
      run(30000, 1);

      // R2: first rollover with start 0xFF after exactly 114 counted cycles
      cur_req = "R2";
      step(0, 1, 0, 8'hFF);
      run(113, 1);
      check("R2", irq, 1'b0);
      step(1, 0, 0, 0);
      check("R2", irq, 1'b1);

      // R8: request stays high through later reloads
      cur_req = "R8";
      run(400, 1);
      check("R8", irq, 1'b1);

      // R5 then R6: stop clears, idle cycles have no effect
      cur_req = "R5";
      step(1, 0, 1, 0);
      check("R5", irq, 1'b0);
      cur_req = "R6";
      run(2000, 1);
      check("R6", irq, 1'b0);

      // R3: start 0xFE, second tick uses carried remainder
      cur_req = "R3";
      step(0, 1, 0, 8'hFE);
      run(227, 1);
      check("R3", irq, 1'b0);
      step(1, 0, 0, 0);
      check("R3", irq, 1'b1);

      // R4: arm while request high clears it
      cur_req = "R4";
      step(1, 1, 0, 8'hFF);
      check("R4", irq, 1'b0);

      // R10: arm with cyc_en high adds no dots, next rollover still at 114
      cur_req = "R10";
      run(113, 1);
      check("R10", irq, 1'b0);
      step(1, 0, 0, 0);
      check("R10", irq, 1'b1);

      // R9: arm and stop together -> stopped, nothing stored
      cur_req = "R9";
      step(1, 1, 1, 8'hFF);
      check("R9", irq, 1'b0);
      run(600, 1);
      check("R9", irq, 1'b0);

      // R7: sparse cycle enables
      cur_req = "R7";
      step(0, 1, 0, 8'hFE);
      for (int i = 0; i < 1500; i++) step(($urandom % 2) == 0, 0, 0, 0);

      // R3 boundary: start 0x00 needs 256 ticks
      cur_req = "R3";
      step(0, 1, 0, 8'h00);
      run(29100, 1);
      check("R3", irq, 1'b1);

      // Random mix of all controls
      cur_req = "R4";
      for (int i = 0; i < 40000; i++) begin
         int sel;
         int v;
         sel = $urandom % 1000;
         v = (($urandom % 4) == 0) ? int'($urandom % 256) : 240 + int'($urandom % 16);
         step(($urandom % 10) < 7, sel < 3, (sel >= 3 && sel < 5) || sel == 0, v);
      end

      summary();
   end

endmodule